// File: doc/BRIEF.md
# Receive SYN and Steady-State Character Filter

This block sits in a serial receive path just after the character assembler. Each assembled character arrives with a one-cycle strobe, a flag that marks it as a partial character, and a flag that says whether the line is character-synchronized. The block either forwards the character to the host-side stream or absorbs it as part of a special-character event. An absorbed event is reported by a one-cycle interrupt strobe that carries a 2-bit match code.

The block works in two ways. When SYN stripping is on, a pair of back-to-back SYN characters raises an interrupt, and the rest of the SYN run is removed from the stream. When both steady-state mode and special-character detect are on, each of three programmable characters is watched in the same way. A character must repeat for two character times before the event is validated. After validation, its repeats are filtered out until a different character arrives. The first character of a candidate pair is held back for one character time. If the pair is not confirmed, the held character is released, so the order of the data is kept.

The control is a three-state machine. `ST_IDLE` has no candidate pending. `ST_HELD` holds one matching character. `ST_FILTER` removes repeats of a validated character. The transitions are named as follows:
- **idle-to-held**: a qualifying character arrives while idle.
- **held-to-filter**: the same qualifying character arrives again, and the interrupt fires.
- **held-to-held**: a different qualifying character arrives. The old character is released and the new one is held.
- **held-to-idle**: a non-qualifying character arrives. The held character is released, then the new character is forwarded.
- **filter-to-idle**: a different character ends the run and is forwarded.

Characters must arrive with at least one idle cycle between strobes.

Top module: `rx_syn_filter`

## Requirements
- R1: After reset, `out_valid` and `irq` are low, and they stay low until a character is presented.
- R2: With `strip_syn_en` set, two consecutive qualifying characters equal to `syn_value` give exactly one `irq` with `irq_code` = 0. Neither of the two is forwarded.
- R3: After a validated pair, further consecutive copies of the same character are dropped. The first different character ends the run, is forwarded, and pair matching starts over from it onward.
- R4: With `strip_syn_en` clear, SYN characters are forwarded as ordinary data and raise no interrupt.
- R5: Special-character matching acts only when both `steady_mode_en` and `spc_detect_en` are set. With either one clear, the programmed characters are forwarded as data.
- R6: Two consecutive qualifying copies of the character in `spc_value1`, `spc_value2` or `spc_value3` give one `irq` with `irq_code` 1, 2 or 3. When registers hold equal values, the lowest-numbered one wins. A SYN match (code 0) takes precedence over all of them.
- R7: Once a special character is validated, its repeats are removed from the output stream (same run rule as R3).
- R8: A single matching character that is not followed by its twin is released as data before the character that broke the pair, so the stream order is preserved.
- R9: A character with `in_partial` set, or one received while `char_synced` is low, is forwarded as data. It never starts or confirms a pair. If it breaks a pending pair, the held character comes out first.
- R10: `out_valid` rises in the cycle after the accepting clock edge, and a released held character comes out first. A second output from the same input follows one cycle later. `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character strobe from the assembler |
| in_char | input | CHAR_W | Assembled character |
| in_partial | input | 1 | Character is partial (not fully assembled) |
| char_synced | input | 1 | Receiver has character synchronization |
| strip_syn_en | input | 1 | Enable SYN pair detection and stripping |
| steady_mode_en | input | 1 | Steady-state mode enable |
| spc_detect_en | input | 1 | Special-character detect enable (gated by steady mode) |
| syn_value | input | CHAR_W | SYN character value |
| spc_value1 | input | CHAR_W | Special character 1 |
| spc_value2 | input | CHAR_W | Special character 2 |
| spc_value3 | input | CHAR_W | Special character 3 |
| out_valid | output | 1 | Forwarded character strobe |
| out_char | output | CHAR_W | Forwarded character |
| irq | output | 1 | Special-character event pulse |
| irq_code | output | 2 | 0 = SYN, 1..3 = special register number |

## Verification
The bench sweeps every four-character sequence over a five-symbol alphabet (SYN, three special characters, and one plain character) under all eight enable combinations. A plain character always closes the sequence, so any held character has to be released. The sweep exposes three kinds of fault:
- a design that loses the held character, or emits it after the breaking character;
- a design that raises a second interrupt inside a filtered run;
- a design that fails to restart pairing after a run ends.

Directed sequences cover partial and unsynchronized characters that arrive in the middle of a pair, the priority among duplicate special registers and SYN, and the exact output cycle. A design that matched partial characters, or that let detect work without steady mode, would show up as an unexpected interrupt or a missing data character.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_FILTER = 2'd2
    } rsf_state_e;

    localparam int unsigned NUM_SPC = 3;
    localparam int unsigned CODE_W  = $clog2(NUM_SPC + 1);

endpackage

// File: rtl/rsf_classify.sv
module rsf_classify #(
    parameter int unsigned CHAR_W  = 8,
    parameter int unsigned NUM_SPC = 3,
    localparam int unsigned CODE_W = $clog2(NUM_SPC + 1)
) (
    input  logic [CHAR_W-1:0]              ch,
    input  logic                           partial,
    input  logic                           synced,
    input  logic                           strip_en,
    input  logic                           steady_en,
    input  logic                           detect_en,
    input  logic [CHAR_W-1:0]              syn_val,
    input  logic [NUM_SPC-1:0][CHAR_W-1:0] spc_val,
    output logic                           hit,
    output logic [CODE_W-1:0]              code
);

    logic             qualified;
    logic             syn_eq;
    logic             spc_active;
    logic [NUM_SPC-1:0] spc_eq;

    assign qualified  = synced && !partial;
    assign syn_eq     = strip_en && (ch == syn_val);
    assign spc_active = steady_en && detect_en;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SPC; gi++) begin : g_spc
            assign spc_eq[gi] = spc_active && (ch == spc_val[gi]);
        end
    endgenerate

    always_comb begin
        hit  = 1'b0;
        code = '0;
        if (qualified) begin
            if (syn_eq) begin
                hit  = 1'b1;
                code = '0;
            end else begin
                // lowest-numbered register wins, so scan from the top down
                for (int i = NUM_SPC - 1; i >= 0; i--) begin
                    if (spc_eq[i]) begin
                        hit  = 1'b1;
                        code = CODE_W'(i + 1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rsf_fsm.sv
module rsf_fsm
    import rsf_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              hit,
    input  logic [CODE_W-1:0] code,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    output logic              irq,
    output logic [CODE_W-1:0] irq_code
);

    rsf_state_e        state_q, state_d;
    logic [CHAR_W-1:0] held_char_q, held_char_d;
    logic [CODE_W-1:0] held_code_q, held_code_d;
    logic              pend_valid_q, pend_valid_d;
    logic [CHAR_W-1:0] pend_char_q, pend_char_d;
    logic              ov_d;
    logic [CHAR_W-1:0] oc_d;
    logic              irq_d;
    logic [CODE_W-1:0] ic_d;

    logic same_as_held;
    assign same_as_held = hit && (in_char == held_char_q);

    // next-state and next-output decode
    always_comb begin
        state_d      = state_q;
        held_char_d  = held_char_q;
        held_code_d  = held_code_q;
        pend_valid_d = 1'b0;
        pend_char_d  = pend_char_q;
        ov_d         = 1'b0;
        oc_d         = out_char;
        irq_d        = 1'b0;
        ic_d         = irq_code;

        if (pend_valid_q) begin
            ov_d = 1'b1;
            oc_d = pend_char_q;
        end

        if (in_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hit) begin
                        // idle-to-held
                        state_d     = ST_HELD;
                        held_char_d = in_char;
                        held_code_d = code;
                    end else begin
                        ov_d = 1'b1;
                        oc_d = in_char;
                    end
                end
                ST_HELD: begin
                    if (same_as_held && (code == held_code_q)) begin
                        // held-to-filter
                        state_d = ST_FILTER;
                        irq_d   = 1'b1;
                        ic_d    = held_code_q;
                    end else begin
                        ov_d = 1'b1;
                        oc_d = held_char_q;
                        if (hit) begin
                            // held-to-held
                            held_char_d = in_char;
                            held_code_d = code;
                        end else begin
                            // held-to-idle
                            pend_valid_d = 1'b1;
                            pend_char_d  = in_char;
                            state_d      = ST_IDLE;
                        end
                    end
                end
                ST_FILTER: begin
                    if (!same_as_held) begin
                        // filter-to-idle
                        ov_d    = 1'b1;
                        oc_d    = in_char;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            held_char_q  <= '0;
            held_code_q  <= '0;
            pend_valid_q <= 1'b0;
            pend_char_q  <= '0;
        end else begin
            state_q      <= state_d;
            held_char_q  <= held_char_d;
            held_code_q  <= held_code_d;
            pend_valid_q <= pend_valid_d;
            pend_char_q  <= pend_char_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_char  <= '0;
            irq       <= 1'b0;
            irq_code  <= '0;
        end else begin
            out_valid <= ov_d;
            out_char  <= oc_d;
            irq       <= irq_d;
            irq_code  <= ic_d;
        end
    end

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !out_valid);

    assert_out_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_valid) || $past(pend_valid_q)));

    assert_input_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);

    assert_filter_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILTER && in_valid && same_as_held) |=> !out_valid);

    assert_held_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && in_valid && !hit)
        |=> (out_valid && out_char == $past(held_char_q)) ##1 out_valid);

endmodule

// File: rtl/rx_syn_filter.sv
module rx_syn_filter
    import rsf_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_partial,
    input  logic              char_synced,
    input  logic              strip_syn_en,
    input  logic              steady_mode_en,
    input  logic              spc_detect_en,
    input  logic [CHAR_W-1:0] syn_value,
    input  logic [CHAR_W-1:0] spc_value1,
    input  logic [CHAR_W-1:0] spc_value2,
    input  logic [CHAR_W-1:0] spc_value3,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    output logic              irq,
    output logic [1:0]        irq_code
);

    logic [NUM_SPC-1:0][CHAR_W-1:0] spc_bus;
    logic                           hit;
    logic [CODE_W-1:0]              code;

    assign spc_bus = {spc_value3, spc_value2, spc_value1};

    rsf_classify #(
        .CHAR_W (CHAR_W),
        .NUM_SPC(NUM_SPC)
    ) u_classify (
        .ch       (in_char),
        .partial  (in_partial),
        .synced   (char_synced),
        .strip_en (strip_syn_en),
        .steady_en(steady_mode_en),
        .detect_en(spc_detect_en),
        .syn_val  (syn_value),
        .spc_val  (spc_bus),
        .hit      (hit),
        .code     (code)
    );

    rsf_fsm #(
        .CHAR_W(CHAR_W),
        .CODE_W(CODE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_char  (in_char),
        .hit      (hit),
        .code     (code),
        .out_valid(out_valid),
        .out_char (out_char),
        .irq      (irq),
        .irq_code (irq_code)
    );

    assert_unsync_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!char_synced || in_partial)) |=> (out_valid && !irq));

    assert_detect_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_code != 2'd0) |-> $past(steady_mode_en && spc_detect_en));

    assert_syn_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_code == 2'd0) |-> $past(strip_syn_en));

endmodule

// File: tb/rx_syn_filter_test.sv
module rx_syn_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_char = '0;
    logic       in_partial = 1'b0;
    logic       char_synced = 1'b1;
    logic       strip_syn_en = 1'b0;
    logic       steady_mode_en = 1'b0;
    logic       spc_detect_en = 1'b0;
    logic [7:0] syn_value = 8'h16;
    logic [7:0] spc_value1 = 8'h41;
    logic [7:0] spc_value2 = 8'h42;
    logic [7:0] spc_value3 = 8'h43;
    logic       out_valid;
    logic [7:0] out_char;
    logic       irq;
    logic [1:0] irq_code;

    always #10 clk = ~clk;

    rx_syn_filter #(.CHAR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
        .in_partial(in_partial), .char_synced(char_synced),
        .strip_syn_en(strip_syn_en), .steady_mode_en(steady_mode_en),
        .spc_detect_en(spc_detect_en), .syn_value(syn_value),
        .spc_value1(spc_value1), .spc_value2(spc_value2), .spc_value3(spc_value3),
        .out_valid(out_valid), .out_char(out_char), .irq(irq), .irq_code(irq_code)
    );

    int checks = 0;
    int fails  = 0;

    // stimulus sequence
    logic [7:0] sq_c[8];
    bit         sq_p[8];
    bit         sq_s[8];
    int         sq_n;

    // expected
    logic [7:0] exp_out[16];
    int         exp_n;
    int         exp_irq[8];
    int         exp_irq_n;

    // observed (cleared by reset)
    logic [7:0] obs_out[16];
    int         obs_n;
    int         obs_irq[8];
    int         obs_irq_n;

    always @(negedge clk) begin
        if (!rst_n) begin
            obs_n     = 0;
            obs_irq_n = 0;
        end else begin
            if (out_valid) begin
                if (obs_n < 16) obs_out[obs_n] = out_char;
                obs_n = obs_n + 1;
            end
            if (irq) begin
                if (obs_irq_n < 8) obs_irq[obs_irq_n] = int'(irq_code);
                obs_irq_n = obs_irq_n + 1;
            end
        end
    end

    function automatic int ref_code(logic [7:0] c, bit p, bit s);
        if (!s || p) return -1;
        if (strip_syn_en && c == syn_value) return 0;
        if (steady_mode_en && spc_detect_en) begin
            if (c == spc_value1) return 1;
            if (c == spc_value2) return 2;
            if (c == spc_value3) return 3;
        end
        return -1;
    endfunction

    task automatic push_out(logic [7:0] c);
        exp_out[exp_n] = c;
        exp_n = exp_n + 1;
    endtask

    // expected stream computed from the requirement text
    task automatic model_seq();
        int st = 0;
        logic [7:0] h = '0;
        int hc = 0;
        exp_n = 0;
        exp_irq_n = 0;
        for (int i = 0; i < sq_n; i++) begin
            int k = ref_code(sq_c[i], sq_p[i], sq_s[i]);
            if (st == 0) begin
                if (k >= 0) begin st = 1; h = sq_c[i]; hc = k; end
                else push_out(sq_c[i]);
            end else if (st == 1) begin
                if (k >= 0 && sq_c[i] == h) begin
                    exp_irq[exp_irq_n] = hc; exp_irq_n++; st = 2;
                end else begin
                    push_out(h);
                    if (k >= 0) begin h = sq_c[i]; hc = k; end
                    else begin push_out(sq_c[i]); st = 0; end
                end
            end else begin
                if (!(k >= 0 && sq_c[i] == h)) begin push_out(sq_c[i]); st = 0; end
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic send(logic [7:0] c, bit p, bit s);
        @(posedge clk);
        #1;
        in_valid = 1'b1; in_char = c; in_partial = p; char_synced = s;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_partial = 1'b0; char_synced = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic run_and_check(string tag);
        bit bad = 0;
        do_reset();
        model_seq();
        for (int i = 0; i < sq_n; i++) send(sq_c[i], sq_p[i], sq_s[i]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (obs_n != exp_n || obs_irq_n != exp_irq_n) bad = 1;
        else begin
            for (int i = 0; i < exp_n; i++) if (obs_out[i] != exp_out[i]) bad = 1;
            for (int i = 0; i < exp_irq_n; i++) if (obs_irq[i] != exp_irq[i]) bad = 1;
        end
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s: actual %0d chars/%0d irqs (first %h), expected %0d chars/%0d irqs (first %h)",
                     tag, obs_n, obs_irq_n, obs_out[0], exp_n, exp_irq_n, exp_out[0]);
        end
    endtask

    function automatic logic [7:0] sym(int i);
        case (i)
            0: return 8'h16;
            1: return 8'h41;
            2: return 8'h42;
            3: return 8'h43;
            default: return 8'h55;
        endcase
    endfunction

    task automatic set_seq(int n, logic [7:0] a0, logic [7:0] a1, logic [7:0] a2,
                           logic [7:0] a3, logic [7:0] a4, logic [7:0] a5, logic [7:0] a6);
        sq_n = n;
        sq_c[0] = a0; sq_c[1] = a1; sq_c[2] = a2; sq_c[3] = a3;
        sq_c[4] = a4; sq_c[5] = a5; sq_c[6] = a6; sq_c[7] = 8'h55;
        for (int i = 0; i < 8; i++) begin sq_p[i] = 0; sq_s[i] = 1; end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0 || irq !== 1'b0) begin
                fails++;
                $display("FAIL R1: actual out_valid=%b irq=%b, expected 0 0", out_valid, irq);
            end
        end

        // R10: output cycle of a plain character
        strip_syn_en = 1'b0; steady_mode_en = 1'b0; spc_detect_en = 1'b0;
        @(posedge clk); #1;
        in_valid = 1'b1; in_char = 8'h5a;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R10: actual out_valid=%b before edge, expected 0", out_valid);
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || out_char !== 8'h5a) begin
            fails++; $display("FAIL R10: actual %b/%h, expected 1/5a", out_valid, out_char);
        end
        @(posedge clk); #1;
        checks++;
        if (out_valid !== 1'b0) begin
            fails++; $display("FAIL R10: actual out_valid=%b after one cycle, expected 0", out_valid);
        end

        // sweep: R2 R3 R4 R5 R6 R7 R8 R10
        for (int cfg = 0; cfg < 8; cfg++) begin
            strip_syn_en = cfg[0]; steady_mode_en = cfg[1]; spc_detect_en = cfg[2];
            for (int s = 0; s < 625; s++) begin
                set_seq(5, sym(s % 5), sym((s / 5) % 5), sym((s / 25) % 5),
                        sym((s / 125) % 5), 8'h55, 8'h00, 8'h00);
                run_and_check("R2 R3 R4 R5 R6 R7 R8 sweep");
            end
        end

        // R9: unsynchronized SYN run forwarded
        strip_syn_en = 1'b1; steady_mode_en = 1'b1; spc_detect_en = 1'b1;
        set_seq(4, 8'h16, 8'h16, 8'h16, 8'h55, 0, 0, 0);
        sq_s[0] = 0; sq_s[1] = 0; sq_s[2] = 0;
        run_and_check("R9 unsynced");

        // R9: partial character breaks a pending pair
        set_seq(3, 8'h16, 8'h16, 8'h55, 0, 0, 0, 0);
        sq_p[1] = 1;
        run_and_check("R9 partial");

        // R9: partial special characters
        set_seq(4, 8'h41, 8'h41, 8'h41, 8'h55, 0, 0, 0);
        sq_p[0] = 1; sq_p[1] = 1;
        run_and_check("R9 partial special");

        // R3: restart after run ends
        set_seq(7, 8'h16, 8'h16, 8'h16, 8'h41, 8'h16, 8'h16, 8'h55);
        run_and_check("R3 restart");

        // R6: duplicate registers, lowest wins; code 3
        strip_syn_en = 1'b0;
        spc_value1 = 8'h60; spc_value2 = 8'h60; spc_value3 = 8'h70;
        set_seq(6, 8'h60, 8'h60, 8'h55, 8'h70, 8'h70, 8'h55, 0);
        run_and_check("R6 priority");

        // R6: SYN precedence over special register
        strip_syn_en = 1'b1; spc_value1 = 8'h16;
        set_seq(3, 8'h16, 8'h16, 8'h55, 0, 0, 0, 0);
        run_and_check("R6 syn precedence");

        // R5: detect enable alone does nothing
        steady_mode_en = 1'b0; strip_syn_en = 1'b0;
        spc_value1 = 8'h41; spc_value2 = 8'h42; spc_value3 = 8'h43;
        set_seq(4, 8'h41, 8'h41, 8'h41, 8'h55, 0, 0, 0);
        run_and_check("R5 gated");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule